// File: doc/BRIEF.md
# UART Modem Control and Loopback Router

This block holds the byte-wide modem control register of a UART and performs the signal routing that the register selects. Software writes the register through a simple synchronous write port and reads it back combinationally. Four bits drive the active-low modem output pins. The remaining control bits pick a loopback arrangement. Local loopback turns the serial path and the modem lines back into the chip. Remote loopback sends incoming line data straight back out and disables the receiver. Automatic echo sends incoming data back out and leaves the receiver running.

The block sits between the pins and a UART core. The core's transmitter output, receiver input, receiver enable and modem status inputs are plain ports here. The shift registers, baud generation and interrupts belong to the core.

Top module: `uart_mctl_router`

## Requirements
- R1: After reset the register reads 0x00. TXD follows the transmitter output, and all four modem output pins are 1.
- R2: Bits 0, 1, 2 and 3 control the DTR, RTS, OUT1 and OUT2 pins. Each pin is active low: a set bit drives its pin to 0 and a clear bit drives it to 1. This holds whenever local loopback is off.
- R3: A write takes effect at the next clock edge. A read returns all 8 bits as last written, including reserved bit 7 and the reserved field code 11.
- R4: Field bits 6:5 select the remote mode: 00 is off, 01 is remote loopback, 10 is automatic echo and 11 behaves as off. The field has effect only when bit 4 is 0.
- R5: In remote loopback, TXD equals RXD and the receiver enable output is 0. The receiver input still carries RXD.
- R6: In automatic echo, TXD equals RXD, the receiver enable is 1 and the receiver input equals RXD.
- R7: When bit 4 is set (local loopback), TXD is 1 and all four modem output pins are 1. The receiver input equals the transmitter output and the receiver enable is 1, whatever the field value.
- R8: In local loopback the status inputs seen by the core take the asserted sense of the control bits: DSR from DTR (bit 0), CTS from RTS (bit 1), RI from OUT1 (bit 2) and DCD from OUT2 (bit 3). The RXD, DSR, CTS, RI and DCD pins have no effect.
- R9: Outside local loopback, each core status input equals the inverse of its active-low pin, and the receiver input equals RXD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| pin_txd | output | 1 | Serial line output pin |
| pin_rxd | input | 1 | Serial line input pin |
| pin_dtr_n | output | 1 | Data terminal ready, active low |
| pin_rts_n | output | 1 | Request to send, active low |
| pin_out1_n | output | 1 | User output 1, active low |
| pin_out2_n | output | 1 | User output 2, active low |
| pin_dsr_n | input | 1 | Data set ready, active low |
| pin_cts_n | input | 1 | Clear to send, active low |
| pin_ri_n | input | 1 | Ring indicator, active low |
| pin_dcd_n | input | 1 | Carrier detect, active low |
| core_tx | input | 1 | Transmitter serial output |
| core_rx | output | 1 | Receiver serial input |
| core_rx_en | output | 1 | Receiver enable |
| core_dsr | output | 1 | DSR status to core, active high |
| core_cts | output | 1 | CTS status to core, active high |
| core_ri | output | 1 | RI status to core, active high |
| core_dcd | output | 1 | DCD status to core, active high |

## Verification
The assertions check the mode routing on every cycle:
- TXD selection, receiver enable and receiver source for each decoded mode.
- Forced-high pins and status feedback in local loopback.
- The one-cycle latency between a write and the read-back.

Only the bench's scenarios show the following:
- The reset value.
- The priority of local loopback over each field code, including the reserved code 11.
- The pins being truly ignored under random pin activity.
- The exact bit-to-pin mapping, which the bench's independent model predicts.

// File: rtl/uart_mctl_router.sv
module uart_mctl_router #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         pin_txd,
  input  logic         pin_rxd,
  output logic         pin_dtr_n,
  output logic         pin_rts_n,
  output logic         pin_out1_n,
  output logic         pin_out2_n,
  input  logic         pin_dsr_n,
  input  logic         pin_cts_n,
  input  logic         pin_ri_n,
  input  logic         pin_dcd_n,
  input  logic         core_tx,
  output logic         core_rx,
  output logic         core_rx_en,
  output logic         core_dsr,
  output logic         core_cts,
  output logic         core_ri,
  output logic         core_dcd
);
  logic [W-1:0] ctl_q;
  logic         lb_local, lb_remote, lb_echo;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= '0;
    else if (reg_we) ctl_q <= reg_wdata;

  assign reg_rdata = ctl_q;

  assign lb_local  = ctl_q[4];
  assign lb_remote = !lb_local && (ctl_q[6:5] == 2'b01);
  assign lb_echo   = !lb_local && (ctl_q[6:5] == 2'b10);

  always_comb begin
    if (lb_local)                  pin_txd = 1'b1;
    else if (lb_remote || lb_echo) pin_txd = pin_rxd;
    else                           pin_txd = core_tx;
  end

  assign core_rx    = lb_local ? core_tx : pin_rxd;
  assign core_rx_en = !lb_remote;

  assign pin_dtr_n  = lb_local | ~ctl_q[0];
  assign pin_rts_n  = lb_local | ~ctl_q[1];
  assign pin_out1_n = lb_local | ~ctl_q[2];
  assign pin_out2_n = lb_local | ~ctl_q[3];

  assign core_dsr = lb_local ? ctl_q[0] : ~pin_dsr_n;
  assign core_cts = lb_local ? ctl_q[1] : ~pin_cts_n;
  assign core_ri  = lb_local ? ctl_q[2] : ~pin_ri_n;
  assign core_dcd = lb_local ? ctl_q[3] : ~pin_dcd_n;
endmodule

module uart_mctl_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       pin_txd,
  input logic       pin_rxd,
  input logic       pin_dtr_n,
  input logic       pin_rts_n,
  input logic       pin_out1_n,
  input logic       pin_out2_n,
  input logic       core_tx,
  input logic       core_rx,
  input logic       core_rx_en,
  input logic       core_dsr,
  input logic       core_dcd
);
  // R3
  wr_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata == $past(reg_wdata));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(reg_rdata));
  // R7
  local_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4] |-> pin_txd && pin_dtr_n && pin_rts_n && pin_out1_n && pin_out2_n
                     && core_rx == core_tx && core_rx_en);
  // R8
  local_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4] |-> core_dsr == reg_rdata[0] && core_dcd == reg_rdata[3]);
  // R5
  remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[4] && reg_rdata[6:5] == 2'b01) |-> pin_txd == pin_rxd && !core_rx_en);
  // R6
  echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[4] && reg_rdata[6:5] == 2'b10) |-> pin_txd == pin_rxd && core_rx_en
                                                   && core_rx == pin_rxd);
  // R4
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[4] && reg_rdata[6] == reg_rdata[5]) |-> pin_txd == core_tx && core_rx_en);
  // R2
  dtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[4] |-> pin_dtr_n != reg_rdata[0]);
endmodule

bind uart_mctl_router uart_mctl_router_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .pin_txd(pin_txd), .pin_rxd(pin_rxd),
  .pin_dtr_n(pin_dtr_n), .pin_rts_n(pin_rts_n), .pin_out1_n(pin_out1_n),
  .pin_out2_n(pin_out2_n), .core_tx(core_tx), .core_rx(core_rx),
  .core_rx_en(core_rx_en), .core_dsr(core_dsr), .core_dcd(core_dcd));

// File: tb/test_uart_mctl_router.sv
module test_uart_mctl_router;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic pin_txd, pin_rxd = 1, pin_dtr_n, pin_rts_n, pin_out1_n, pin_out2_n;
  logic pin_dsr_n = 1, pin_cts_n = 1, pin_ri_n = 1, pin_dcd_n = 1;
  logic core_tx = 1, core_rx, core_rx_en, core_dsr, core_cts, core_ri, core_dcd;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  uart_mctl_router i_uart_mctl_router (.*);

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // Expected outputs packed as {txd, dtr,rts,o1,o2, rx, rxen, dsr,cts,ri,dcd}
  function automatic logic [10:0] model(input logic [7:0] c, input logic rxd, tx,
                                         input logic [3:0] st_n);
    logic loc, rem, ech, txd, rx, en;
    logic [3:0] outs, st;
    loc = c[4];
    rem = !loc && c[6:5] == 2'b01;
    ech = !loc && c[6:5] == 2'b10;
    txd = loc ? 1'b1 : (rem || ech) ? rxd : tx;
    outs = loc ? 4'hF : ~{c[0], c[1], c[2], c[3]};
    rx = loc ? tx : rxd;
    en = !rem;
    st = loc ? {c[0], c[1], c[2], c[3]} : ~st_n;
    return {txd, outs, rx, en, st};
  endfunction

  task automatic check(input string req, input logic [10:0] act, exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_we = 1; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic cmp_all(input string req);
    logic [7:0] c;
    c = reg_wdata;
    check({req, " route"},
          {pin_txd, pin_dtr_n, pin_rts_n, pin_out1_n, pin_out2_n, core_rx, core_rx_en,
           core_dsr, core_cts, core_ri, core_dcd},
          model(c, pin_rxd, core_tx, {pin_dsr_n, pin_cts_n, pin_ri_n, pin_dcd_n}));
    check({req, " readback"}, {3'b0, reg_rdata}, {3'b0, c});
  endtask

  task automatic pins(input logic [6:0] v);
    {pin_rxd, core_tx, pin_dsr_n, pin_cts_n, pin_ri_n, pin_dcd_n} = v[5:0];
    #1;
  endtask

  initial begin
    void'($urandom(1234));
    #35 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", {3'b0, reg_rdata}, 11'h000);
    check("R1", {pin_txd, pin_dtr_n, pin_rts_n, pin_out1_n, pin_out2_n}, 11'b11111);
    // R2 each output bit alone
    for (int b = 0; b < 4; b++) begin
      wr(8'(1 << b)); cmp_all("R2");
    end
    // R3 reserved bit and code 11 read back, code 11 acts off (R4)
    wr(8'hE0); cmp_all("R3");
    core_tx = 0; #1; check("R4", {10'b0, pin_txd}, 11'd0);
    // R5 remote, toggle rxd
    wr(8'h20);
    for (int k = 0; k < 4; k++) begin pins(7'($urandom)); cmp_all("R5"); end
    // R6 echo
    wr(8'h4F);
    for (int k = 0; k < 4; k++) begin pins(7'($urandom)); cmp_all("R6"); end
    // R7/R8 local beats each field code; pins ignored
    for (int f = 0; f < 4; f++) begin
      wr(8'(f << 5) | 8'h1A);
      for (int k = 0; k < 3; k++) begin pins(7'($urandom)); cmp_all("R7 R8"); end
    end
    wr(8'h15); pins(7'h00); cmp_all("R8");
    // R9 status passthrough when off
    wr(8'h00);
    for (int k = 0; k < 4; k++) begin pins(7'($urandom)); cmp_all("R9"); end
    // random mix
    for (int k = 0; k < 200; k++) begin
      wr(8'($urandom)); pins(7'($urandom)); cmp_all("R4 R7 R9");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule